// File: doc/BRIEF.md
# DRAM Sense and Restore Sequencer

This block drives one column of single-transistor DRAM storage through a full access cycle against a dummy reference cell. The dummy cell sits on a complementary dummy bit line. A read destroys the charge in the selected cell, so every access has to finish in a fixed order:

- both sense nodes are precharged;
- the data cell and the dummy cell are selected together;
- the latch resolves the difference and writes the winning value back;
- the cell is isolated;
- the two bit lines are equalised;
- the dummy is released, which leaves it at its reference level.

Each of these six phases lasts `PHASE_LEN` clock cycles. A behavioural storage array holds the cells. Analog charge sharing is modelled as a digital comparison against the dummy reference.

A requester raises `req` with `we`, the address and `wdata`, and keeps `req` high until it sees `done`. The block samples the request only when it is idle. A read returns the sensed bit on `rdata`. A write forces the latch to `wdata` during the restore phase.

Top module: `dram_sense_seq`

## Requirements
- R1: While `rstN` is low and afterwards until the first access, `done` is 0, `rdata` is 0 and every cell holds 0.
- R2: A request is accepted on a rising edge where the block is idle and `req` is 1. `done` goes high on the edge 6*PHASE_LEN cycles after the acceptance edge and stays high for exactly one cycle.
- R3: A read (`we`=0) updates `rdata` to the stored bit on the edge 3*PHASE_LEN cycles after acceptance, and `rdata` holds that value until the next read. The sensed value is written back into the cell, so repeated reads of a cell return the same bit.
- R4: A write (`we`=1) stores `wdata` in the cell at index row*COLS+col and leaves `rdata` unchanged.
- R5: While an access is in progress, `req`, `we`, `row`, `col` and `wdata` have no effect. The access uses the values captured at acceptance, and no other cell is touched.
- R6: The cell select and the dummy select rise in the same cycle. Write-back happens only while both selects are high. The dummy select falls only after the cell select has fallen and the bit lines are equal.
- R7: Every cell holds a 0 or a 1 independently of the others. At each selection both sense nodes are precharged and the dummy is at its reference level, so both values are sensed correctly.
- R8: If `req` stays high after `done`, the next access is accepted two edges after the edge that raised `done`. The next `done` then follows 6*PHASE_LEN+2 cycles after the previous one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request, held until done |
| we | input | 1 | 1 = write, 0 = read |
| row | input | ROW_W | Row address |
| col | input | COL_W | Column address |
| wdata | input | 1 | Write data bit |
| rdata | output | 1 | Last read result |
| done | output | 1 | One-cycle pulse at the end of the access |

## Verification
The hardest case to reach from the ports is a request whose inputs change while the phase sequence is running. The bench starts a read, switches the address, `we` and `wdata` mid-sequence, and then confirms two things: the original cell's value comes back, and the other cell is left untouched. A second hard case is a back-to-back access with `req` held high across `done`. The bench provokes it by never dropping `req` between two reads and timing the gap between the two `done` pulses.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_PRECH, PH_SELECT, PH_LATCH,
    PH_ISOLATE, PH_EQUAL, PH_DRST, PH_DONE
  } phase_t;

  typedef struct packed {
    logic capture;
    logic prech;
    logic select;
    logic fire;
    logic restore;
    logic isolate;
    logic equalise;
    logic dummyRel;
  } strobes_t;
endpackage

// File: rtl/dsr_ctrl.sv
module dsr_ctrl
  import dsr_pkg::*;
#(
  parameter int PHASE_LEN = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     req,
  output strobes_t stb,
  output logic     done
);
  localparam int CNT_W = (PHASE_LEN > 1) ? $clog2(PHASE_LEN) : 1;

  phase_t state;
  logic [CNT_W-1:0] cnt;
  logic lastCyc, firstCyc;

  assign lastCyc  = (cnt == CNT_W'(PHASE_LEN - 1));
  assign firstCyc = (cnt == '0);

  function automatic phase_t nextPh(phase_t p);
    case (p)
      PH_PRECH:   return PH_SELECT;
      PH_SELECT:  return PH_LATCH;
      PH_LATCH:   return PH_ISOLATE;
      PH_ISOLATE: return PH_EQUAL;
      PH_EQUAL:   return PH_DRST;
      default:    return PH_DONE;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= PH_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        PH_IDLE: if (req) begin
          state <= PH_PRECH;
          cnt   <= '0;
        end
        PH_DONE: state <= PH_IDLE;
        default: if (lastCyc) begin
          state <= nextPh(state);
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      endcase
    end
  end

  always_comb begin
    stb          = '0;
    stb.capture  = (state == PH_IDLE) && req;
    stb.prech    = (state == PH_PRECH) && firstCyc;
    stb.select   = (state == PH_SELECT) && firstCyc;
    stb.fire     = (state == PH_LATCH) && firstCyc;
    stb.restore  = (state == PH_LATCH) && lastCyc;
    stb.isolate  = (state == PH_ISOLATE) && firstCyc;
    stb.equalise = (state == PH_EQUAL) && firstCyc;
    stb.dummyRel = (state == PH_DRST) && lastCyc;
  end

  assign done = (state == PH_DONE);

  // R2: done lasts one cycle and follows the dummy-reset phase
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_done_after_drst_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(state) == PH_DRST);
  // R5: a new sequence starts only from idle
  p_start_from_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_PRECH && firstCyc) |-> $past(state) == PH_IDLE);
  // R6: at most one sequencing strobe at a time (restore may coincide with fire)
  p_strobe_onehot_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.capture, stb.prech, stb.select, stb.fire,
              stb.isolate, stb.equalise, stb.dummyRel}));
endmodule

// File: rtl/dsr_datapath.sv
module dsr_datapath
  import dsr_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 4,
  localparam int CELLS = ROWS * COLS,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int IDX_W = (CELLS > 1) ? $clog2(CELLS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         stb,
  input  logic             we,
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col,
  input  logic             wdata,
  output logic             rdata
);
  logic [CELLS-1:0] mem;
  logic [ROW_W-1:0] rowQ;
  logic [COL_W-1:0] colQ;
  logic weQ, wdQ;
  logic cellSel, dumSel, dummyRef;
  logic blNode, dblNode, blBelowRef;
  logic [IDX_W-1:0] idx;
  logic resolved;

  assign idx      = IDX_W'(rowQ) * IDX_W'(COLS) + IDX_W'(colQ);
  // cell 0 pulls the bit line further below the dummy reference
  assign resolved = weQ ? wdQ : ~blBelowRef;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mem        <= '0;
      rowQ       <= '0;
      colQ       <= '0;
      weQ        <= 1'b0;
      wdQ        <= 1'b0;
      cellSel    <= 1'b0;
      dumSel     <= 1'b0;
      dummyRef   <= 1'b1;
      blNode     <= 1'b1;
      dblNode    <= 1'b1;
      blBelowRef <= 1'b0;
      rdata      <= 1'b0;
    end else begin
      if (stb.capture) begin
        rowQ <= row;
        colQ <= col;
        weQ  <= we;
        wdQ  <= wdata;
      end
      if (stb.prech) begin
        blNode  <= 1'b1;
        dblNode <= 1'b1;
      end
      if (stb.select) begin
        cellSel    <= 1'b1;
        dumSel     <= 1'b1;
        blBelowRef <= ~mem[idx];
        mem[idx]   <= 1'b0;   // charge shared away: read is destructive
        dummyRef   <= 1'b0;
      end
      if (stb.fire) begin
        blNode  <= resolved;
        dblNode <= ~resolved;
      end
      if (stb.restore) begin
        mem[idx] <= resolved;
        if (!weQ) rdata <= resolved;
      end
      if (stb.isolate) cellSel <= 1'b0;
      if (stb.equalise) begin
        blNode  <= 1'b1;
        dblNode <= 1'b1;
      end
      if (stb.dummyRel) begin
        dumSel   <= 1'b0;
        dummyRef <= 1'b1;
      end
    end
  end

  // R6: selects rise together, write-back only while selected,
  // dummy released after isolation and equalisation
  p_sel_together_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cellSel) |-> $rose(dumSel));
  p_restore_selected_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.restore |-> (cellSel && dumSel));
  p_dummy_last_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dumSel) |-> (!cellSel && blNode == dblNode));
  // R7: selection starts from precharged nodes and a reference-level dummy
  p_ref_ready_r7: assert property (@(posedge clk) disable iff (!rstN)
    stb.select |-> (dummyRef && blNode && dblNode));
  p_latch_split_r7: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.fire) |-> (blNode != dblNode));
  // R5: captured access fields stay put while the cell is selected
  p_hold_addr_r5: assert property (@(posedge clk) disable iff (!rstN)
    cellSel |=> ($stable(rowQ) && $stable(colQ) && $stable(weQ)));
endmodule

// File: rtl/dram_sense_seq.sv
module dram_sense_seq
  import dsr_pkg::*;
#(
  parameter int ROWS      = 8,
  parameter int COLS      = 4,
  parameter int PHASE_LEN = 2,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             req,
  input  logic             we,
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col,
  input  logic             wdata,
  output logic             rdata,
  output logic             done
);
  strobes_t stb;

  dsr_ctrl #(.PHASE_LEN(PHASE_LEN)) u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .req  (req),
    .stb  (stb),
    .done (done)
  );

  dsr_datapath #(.ROWS(ROWS), .COLS(COLS)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .stb   (stb),
    .we    (we),
    .row   (row),
    .col   (col),
    .wdata (wdata),
    .rdata (rdata)
  );
endmodule

// File: tb/tb_dram_sense_seq.sv
module tb_dram_sense_seq;
  localparam int ROWS = 8, COLS = 4, PL = 2;
  localparam int LAT = 6 * PL;
  localparam int CELLS = ROWS * COLS;

  logic clk = 1'b0, rstN = 1'b0, req = 1'b0, we = 1'b0, wdata = 1'b0;
  logic [2:0] row = '0;
  logic [1:0] col = '0;
  logic rdata, done;

  int checks = 0, fails = 0, cyc = 0;
  bit shadow [CELLS];

  always #10 clk = ~clk;

  dram_sense_seq #(.ROWS(ROWS), .COLS(COLS), .PHASE_LEN(PL)) dut (
    .clk(clk), .rstN(rstN), .req(req), .we(we), .row(row), .col(col),
    .wdata(wdata), .rdata(rdata), .done(done)
  );

  // behavioural reference model
  bit mMem [CELLS];
  bit mBusy, mDone, mRdata, mWe, mWd;
  int mLeft, mIdx;

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy <= 0; mDone <= 0; mRdata <= 0; mLeft <= 0;
      for (int i = 0; i < CELLS; i++) mMem[i] <= 0;
    end else if (mDone) begin
      mDone <= 0;
    end else if (mBusy) begin
      if (mLeft == 3 * PL + 1) begin
        if (mWe) mMem[mIdx] <= mWd;
        else     mRdata <= mMem[mIdx];
      end
      if (mLeft == 1) begin mBusy <= 0; mDone <= 1; end
      mLeft <= mLeft - 1;
    end else if (req) begin
      mBusy <= 1; mLeft <= LAT;
      mIdx <= int'(row) * COLS + int'(col);
      mWe <= we; mWd <= wdata;
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN) begin
      check(done == mDone, "R2 done vs model", int'(done), int'(mDone));
      check(rdata == mRdata, "R3 rdata vs model", int'(rdata), int'(mRdata));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      fails++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 60000);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic access(bit w, int r, int c, bit d, output int lat);
    @(negedge clk);
    req = 1; we = w; row = 3'(r); col = 2'(c); wdata = d;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!done && lat < 200);
    req = 0;
    if (w) shadow[r * COLS + c] = d;
  endtask

  initial begin
    int lat;
    bit prev;
    for (int i = 0; i < CELLS; i++) shadow[i] = 0;
    repeat (3) @(negedge clk);
    check(done == 0, "R1 done in reset", int'(done), 0);
    check(rdata == 0, "R1 rdata in reset", int'(rdata), 0);
    rstN = 1;
    @(negedge clk);
    check(done == 0 && rdata == 0, "R1 idle after reset", int'({done, rdata}), 0);

    access(0, 5, 3, 0, lat);
    check(rdata == 0, "R1 cell zero after reset", int'(rdata), 0);
    check(lat == LAT + 1, "R2/R6 done latency", lat, LAT + 1);

    // checkerboard-like pattern over all cells (R4, R7)
    for (int i = 0; i < CELLS; i++) begin
      prev = rdata;
      access(1, i / COLS, i % COLS, bit'((i * 5 + i / 3) & 1), lat);
      check(rdata == prev, "R4 rdata unchanged by write", int'(rdata), int'(prev));
    end
    for (int i = 0; i < CELLS; i++) begin
      access(0, i / COLS, i % COLS, 0, lat);
      check(rdata == shadow[i], "R7 read value", int'(rdata), int'(shadow[i]));
    end

    // repeated reads return the same bit after restore (R3)
    access(1, 2, 1, 1, lat);
    for (int k = 0; k < 3; k++) begin
      access(0, 2, 1, 0, lat);
      check(rdata == 1, "R3 repeated read of 1", int'(rdata), 1);
    end
    access(1, 2, 2, 0, lat);
    for (int k = 0; k < 2; k++) begin
      access(0, 2, 2, 1, lat);
      check(rdata == 0, "R3 repeated read of 0", int'(rdata), 0);
    end

    // inputs changed while busy (R5)
    access(1, 6, 0, 1, lat);
    access(1, 6, 1, 0, lat);
    @(negedge clk);
    req = 1; we = 0; row = 3'd6; col = 2'd0;
    repeat (3) @(negedge clk);
    we = 1; row = 3'd6; col = 2'd1; wdata = 1;
    lat = 3;
    while (!done && lat < 200) begin @(negedge clk); lat++; end
    req = 0;
    check(rdata == 1, "R5 busy access keeps captured address", int'(rdata), 1);
    check(lat == LAT + 1, "R5 busy latency", lat, LAT + 1);
    access(0, 6, 1, 0, lat);
    check(rdata == 0, "R5 other cell untouched", int'(rdata), 0);

    // back-to-back with req held (R8)
    access(1, 1, 1, 1, lat);
    @(negedge clk);
    req = 1; we = 0; row = 3'd1; col = 2'd1;
    while (!done) @(negedge clk);
    lat = 0;
    do begin @(negedge clk); lat++; end while (!done && lat < 200);
    req = 0;
    check(lat == LAT + 2, "R8 done-to-done gap", lat, LAT + 2);
    check(rdata == 1, "R8 second read value", int'(rdata), 1);

    repeat (4) @(negedge clk);
    check(done == 0, "R2 done returns low", int'(done), 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule